// File: doc/BRIEF.md
# Byte/Word Switchable Read-Only Memory Port

This block is a clock-synchronous model of the read and program port of a parallel non-volatile memory, 16 bits per word. The port works in one of two organisations. In word organisation every lookup returns a full 16-bit word. In byte organisation one input pin is reused: it stops carrying data bit 15 and becomes the lowest address bit, which picks one half of the addressed word. Two active-low controls gate the outputs. Chip enable selects the device and puts it in standby when high. Output enable lets data onto the bus. The outputs carry no tri-state. Three per-lane drive enables show which lanes would be driven: bits 7..0, bits 14..8 and bit 15.

A program-supply flag changes what the controls do. With the supply active, a low pulse on chip enable while output enable is high writes the word on the data inputs. Chip enable and output enable both low then read the stored word back. A signature flag replaces normal read data with a fixed two-entry identifier. An erase input sweeps the whole array back to all ones, one word per clock. The array depth is a parameter so that simulation stays small; address bits above the implemented depth are ignored.

Pin changes are registered once, so outputs follow the inputs sampled at the previous clock edge. A settle counter holds the data-valid flag low for a set number of cycles after any address or control change.

Top module: `bw_rom_port`

## Requirements
- R1: With the organisation input high, a read (chip enable low, output enable low, program supply low, signature low) drives all three lanes and returns the stored 16-bit word on `d_out`.
- R2: With the organisation input low, `d_in[15]` is the byte select: 0 puts the lower byte (bits 7..0) of the addressed word on `d_out[7:0]`, 1 puts the upper byte (bits 15..8) there.
- R3: In byte organisation only `en_lo` is set; `en_hi` and `en_top` stay low and `d_out[15:8]` reads zero.
- R4: With chip enable low and output enable high, no lane is driven and `data_valid` stays low.
- R5: With chip enable high, no lane is driven, whatever the level of output enable.
- R6: With the signature flag high, program supply low, and chip enable and output enable low, `d_out[7:0]` is 0x20 when `addr[0]` is 0 and 0xB1 when `addr[0]` is 1, and `d_out[15:8]` is zero. The lanes follow the organisation as in R1/R3. With output enable high the signature is not driven.
- R7: With the program supply high and output enable high, the high-to-low transition of chip enable writes `d_in` (all 16 bits) to the addressed word, one write per pulse.
- R8: With the program supply high, chip enable low and output enable low, the stored word is driven for verification. With chip enable high under the supply, nothing is written and no lane is driven.
- R9: Every word holds 0xFFFF after reset or erase. A write can only clear bits: the new word is the old word AND the written value.
- R10: After a change of address, control or organisation inputs, the drive enables appear one clock later. `data_valid` rises only after SETTLE further clock edges without a change.
- R11: A pulse on `erase_req` while idle sets `busy` for exactly DEPTH clock cycles, during which all words are rewritten to 0xFFFF. `busy` then clears.
- R12: After reset no lane is driven, `data_valid` is low and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable; high means standby |
| oe_n | input | 1 | Active-low output enable |
| wide_sel | input | 1 | 1 = word organisation, 0 = byte organisation |
| sig_mode | input | 1 | Signature read request |
| prog_sup | input | 1 | Program supply present |
| addr | input | 20 | Word address |
| d_in | input | 16 | Data pins seen as inputs; bit 15 is the byte select in byte organisation |
| erase_req | input | 1 | Starts an erase sweep |
| d_out | output | 16 | Output data |
| en_lo | output | 1 | Drive enable for bits 7..0 |
| en_hi | output | 1 | Drive enable for bits 14..8 |
| en_top | output | 1 | Drive enable for bit 15 |
| data_valid | output | 1 | Output data is settled |
| busy | output | 1 | Erase sweep in progress |

## Verification
Words are read in both organisations with a mixed word whose halves differ (0x1204), so swapping the halves or dropping the byte select shows up. Repeated programming of one word checks the AND semantics against a plain overwrite. Signature reads with both address parities, in word and byte organisation, tell the identifier path apart from array data. An inhibit phase that toggles data and address under the program supply, followed by an erase, shows whether words stay intact or are restored to ones.

// File: rtl/bwrom_pkg.sv
package bwrom_pkg;

   localparam int PORT_AW = 20;
   localparam int WORD_W  = 16;
   localparam int BYTE_W  = 8;

   localparam logic [BYTE_W-1:0] SIG_EVEN = 8'h20;
   localparam logic [BYTE_W-1:0] SIG_ODD  = 8'hB1;

   typedef enum logic [2:0] {
      PM_IDLE,
      PM_MUTE,
      PM_READ,
      PM_SIG,
      PM_PROG,
      PM_VERIFY
   } port_mode_e;

   typedef struct packed {
      logic               ce_n;
      logic               oe_n;
      logic               wide;
      logic               sig;
      logic               vpp;
      logic [PORT_AW-1:0] addr;
      logic [WORD_W-1:0]  din;
   } pin_snap_t;

   function automatic port_mode_e decode_mode(pin_snap_t s);
      port_mode_e m;
      if (s.ce_n)       m = PM_IDLE;
      else if (s.vpp)   m = s.oe_n ? PM_PROG : PM_VERIFY;
      else if (s.oe_n)  m = PM_MUTE;
      else if (s.sig)   m = PM_SIG;
      else              m = PM_READ;
      return m;
   endfunction

endpackage

// File: rtl/bwrom_mode_dec.sv
module bwrom_mode_dec
   import bwrom_pkg::*;
#(
   parameter int SETTLE = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pin_snap_t  pins,
   output pin_snap_t  snap_q,
   output port_mode_e mode,
   output logic       settled,
   output logic       prog_strobe
);

   localparam pin_snap_t IDLE_SNAP = '{ce_n: 1'b1, oe_n: 1'b1, default: '0};

   logic prev_ce_q;
   logic change;

   // byte select bit counts as part of the address
   assign change = ({pins.ce_n, pins.oe_n, pins.wide, pins.sig, pins.vpp,
                     pins.addr, pins.din[WORD_W-1]} !=
                    {snap_q.ce_n, snap_q.oe_n, snap_q.wide, snap_q.sig, snap_q.vpp,
                     snap_q.addr, snap_q.din[WORD_W-1]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q    <= IDLE_SNAP;
         prev_ce_q <= 1'b1;
      end else begin
         snap_q    <= pins;
         prev_ce_q <= snap_q.ce_n;
      end
   end

   assign mode        = decode_mode(snap_q);
   // first cycle of a chip-enable low pulse under program supply
   assign prog_strobe = (mode == PM_PROG) && prev_ce_q;

   generate
      if (SETTLE == 0) begin : g_no_wait
         assign settled = 1'b1;
      end else begin : g_wait
         localparam int CW = $clog2(SETTLE + 1);
         localparam logic [CW-1:0] LIMIT = CW'(SETTLE);
         logic [CW-1:0] wait_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               wait_q <= '0;
            else if (change)          wait_q <= '0;
            else if (wait_q != LIMIT) wait_q <= wait_q + 1'b1;
         end
         assign settled = (wait_q == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/bwrom_cell_array.sv
module bwrom_cell_array #(
   parameter int AW = 8,
   parameter int W  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_word,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_mask,
   input  logic          erase_req,
   output logic          busy
);

   localparam int DEPTH = 1 << AW;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [W-1:0]  cells_q [DEPTH];
   logic [AW-1:0] sweep_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells_q[i] <= '1;
      end else if (busy_q) begin
         cells_q[sweep_q] <= '1;
      end else if (wr_en) begin
         cells_q[wr_addr] <= cells_q[wr_addr] & wr_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         sweep_q <= '0;
      end else if (busy_q) begin
         if (sweep_q == LAST) busy_q <= 1'b0;
         else                 sweep_q <= sweep_q + 1'b1;
      end else if (erase_req) begin
         busy_q  <= 1'b1;
         sweep_q <= '0;
      end
   end

   assign rd_word = cells_q[rd_addr];
   assign busy    = busy_q;

endmodule

// File: rtl/bwrom_lane_mux.sv
module bwrom_lane_mux
   import bwrom_pkg::*;
(
   input  port_mode_e        mode,
   input  logic              wide,
   input  logic              byte_hi,
   input  logic              addr_lsb,
   input  logic [WORD_W-1:0] word,
   input  logic              settled,
   output logic [WORD_W-1:0] dout,
   output logic              en_lo,
   output logic              en_hi,
   output logic              en_top,
   output logic              valid
);

   always_comb begin
      dout   = '0;
      en_lo  = 1'b0;
      en_hi  = 1'b0;
      en_top = 1'b0;
      case (mode)
         PM_READ, PM_VERIFY: begin
            en_lo = 1'b1;
            if (wide) begin
               dout   = word;
               en_hi  = 1'b1;
               en_top = 1'b1;
            end else begin
               dout[BYTE_W-1:0] = byte_hi ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
            end
         end
         PM_SIG: begin
            en_lo            = 1'b1;
            en_hi            = wide;
            en_top           = wide;
            dout[BYTE_W-1:0] = addr_lsb ? SIG_ODD : SIG_EVEN;
         end
         default: ;
      endcase
   end

   assign valid = en_lo && settled;

endmodule

// File: rtl/bw_rom_port.sv
module bw_rom_port
   import bwrom_pkg::*;
#(
   parameter int DEPTH_LOG2 = 8,
   parameter int SETTLE     = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ce_n,
   input  logic               oe_n,
   input  logic               wide_sel,
   input  logic               sig_mode,
   input  logic               prog_sup,
   input  logic [PORT_AW-1:0] addr,
   input  logic [WORD_W-1:0]  d_in,
   input  logic               erase_req,
   output logic [WORD_W-1:0]  d_out,
   output logic               en_lo,
   output logic               en_hi,
   output logic               en_top,
   output logic               data_valid,
   output logic               busy
);

   generate
      if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > PORT_AW) begin : g_bad_depth
         $error("DEPTH_LOG2 must lie between 1 and the address width");
      end
      if (SETTLE < 0) begin : g_bad_settle
         $error("SETTLE must not be negative");
      end
   endgenerate

   pin_snap_t  pins;
   pin_snap_t  snap_q;
   port_mode_e mode;
   logic       settled;
   logic       prog_strobe;
   logic [WORD_W-1:0] word;

   assign pins = '{ce_n: ce_n, oe_n: oe_n, wide: wide_sel, sig: sig_mode,
                   vpp: prog_sup, addr: addr, din: d_in};

   bwrom_mode_dec #(.SETTLE(SETTLE)) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .pins        (pins),
      .snap_q      (snap_q),
      .mode        (mode),
      .settled     (settled),
      .prog_strobe (prog_strobe)
   );

   bwrom_cell_array #(.AW(DEPTH_LOG2), .W(WORD_W)) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (snap_q.addr[DEPTH_LOG2-1:0]),
      .rd_word   (word),
      .wr_en     (prog_strobe),
      .wr_addr   (snap_q.addr[DEPTH_LOG2-1:0]),
      .wr_mask   (snap_q.din),
      .erase_req (erase_req),
      .busy      (busy)
   );

   bwrom_lane_mux u_mux (
      .mode     (mode),
      .wide     (snap_q.wide),
      .byte_hi  (snap_q.din[WORD_W-1]),
      .addr_lsb (snap_q.addr[0]),
      .word     (word),
      .settled  (settled),
      .dout     (d_out),
      .en_lo    (en_lo),
      .en_hi    (en_hi),
      .en_top   (en_top),
      .valid    (data_valid)
   );

endmodule

// File: rtl/bwrom_chk.sv
module bwrom_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ce_n,
   input logic        oe_n,
   input logic        wide_sel,
   input logic        sig_mode,
   input logic        prog_sup,
   input logic        erase_req,
   input logic [15:0] d_out,
   input logic        en_lo,
   input logic        en_hi,
   input logic        en_top,
   input logic        data_valid,
   input logic        busy
);

   // R5
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n) |-> !(en_lo || en_hi || en_top));

   // R4
   oe_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_n) |-> !(en_lo || en_hi || en_top || data_valid));

   // R3
   byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wide_sel) |-> (!en_hi && !en_top));

   // R1
   word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !ce_n && !oe_n && wide_sel) |-> (en_lo && en_hi && en_top));

   // R6
   sig_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && sig_mode && !prog_sup && !ce_n && !oe_n) |->
         (d_out[15:8] == 8'h00 && (d_out[7:0] == 8'h20 || d_out[7:0] == 8'hB1)));

   // R10
   valid_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> en_lo);

   // R11
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(erase_req));

endmodule

bind bw_rom_port bwrom_chk u_bwrom_chk (.*);

// File: tb/test_bw_rom_port.sv
`timescale 1ns/1ps
module test_bw_rom_port;

   localparam int DLOG   = 8;
   localparam int DEPTH  = 1 << DLOG;
   localparam int SETTLE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, wide_sel = 1'b1, sig_mode = 1'b0;
   logic        prog_sup = 1'b0, erase_req = 1'b0;
   logic [19:0] addr = '0;
   logic [15:0] d_in = '0;
   logic [15:0] d_out;
   logic        en_lo, en_hi, en_top, data_valid, busy;

   always #2 clk = ~clk;

   bw_rom_port #(.DEPTH_LOG2(DLOG), .SETTLE(SETTLE)) i_bw_rom_port (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wide_sel(wide_sel),
      .sig_mode(sig_mode), .prog_sup(prog_sup), .addr(addr), .d_in(d_in),
      .erase_req(erase_req), .d_out(d_out), .en_lo(en_lo), .en_hi(en_hi),
      .en_top(en_top), .data_valid(data_valid), .busy(busy)
   );

   typedef struct {
      string       tag;
      logic [2:0]  en;
      logic [15:0] data;
      logic        valid;
   } exp_t;

   exp_t        sb_q[$];
   event        chk_ev;
   int          n_total = 0;
   int          n_fail  = 0;
   logic [15:0] model [DEPTH];
   bit          done = 0;

   // monitor: compares ports against queued expectations
   initial begin
      forever begin
         @(chk_ev);
         while (sb_q.size() > 0) begin
            exp_t e;
            logic [2:0] got_en;
            e = sb_q.pop_front();
            got_en = {en_top, en_hi, en_lo};
            n_total++;
            if (got_en !== e.en || data_valid !== e.valid ||
                (e.valid && d_out !== e.data)) begin
               n_fail++;
               $display("FAIL %s: en=%b valid=%b data=%h expected en=%b valid=%b data=%h",
                        e.tag, got_en, data_valid, d_out, e.en, e.valid, e.data);
            end
         end
      end
   end

   task automatic push(string tag, logic [2:0] en, logic [15:0] data, logic valid);
      exp_t e;
      e.tag = tag; e.en = en; e.data = data; e.valid = valid;
      sb_q.push_back(e);
      -> chk_ev;
      #0;
   endtask

   task automatic chk_bit(string tag, logic got, logic exp);
      n_total++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic pins(logic ce, logic oe, logic wide, logic sig, logic vpp,
                       logic [19:0] a, logic [15:0] d);
      @(negedge clk);
      ce_n = ce; oe_n = oe; wide_sel = wide; sig_mode = sig; prog_sup = vpp;
      addr = a; d_in = d;
   endtask

   task automatic wait_settled();
      repeat (SETTLE + 1) @(posedge clk);
      #1;
   endtask

   task automatic program_word(logic [19:0] a, logic [15:0] d);
      pins(1, 1, 1, 0, 1, a, d);
      repeat (2) @(posedge clk);
      pins(0, 1, 1, 0, 1, a, d);
      repeat (3) @(posedge clk);
      pins(1, 1, 1, 0, 1, a, d);
      repeat (2) @(posedge clk);
      model[a[DLOG-1:0]] = model[a[DLOG-1:0]] & d;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R12 reset state
      push("R12 reset lanes", 3'b000, 16'h0000, 1'b0);
      chk_bit("R12 busy after reset", busy, 1'b0);

      // R1 + R9 erased word read in word organisation
      pins(0, 0, 1, 0, 0, 20'd9, 16'h0000);
      wait_settled();
      push("R1 R9 erased word", 3'b111, model[9], 1'b1);

      // R7 R8 program then verify under supply
      program_word(20'd5, 16'h1234);
      chk_bit("R8 inhibit lanes idle (en_lo)", en_lo, 1'b0);
      pins(0, 0, 1, 0, 1, 20'd5, 16'h0000);
      wait_settled();
      push("R7 R8 verify", 3'b111, model[5], 1'b1);

      // R9 second write ANDs
      program_word(20'd5, 16'hFF0F);
      pins(0, 0, 1, 0, 0, 20'd5, 16'h0000);
      @(posedge clk); #1;
      // R10 lanes up, not yet valid
      push("R10 early not valid", 3'b111, 16'h0000, 1'b0);
      repeat (SETTLE) @(posedge clk); #1;
      push("R9 R1 AND result 1204", 3'b111, 16'h1204, 1'b1);

      // R2 R3 byte organisation
      pins(0, 0, 0, 0, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R2 R3 lower byte", 3'b001, {8'h00, model[5][7:0]}, 1'b1);
      pins(0, 0, 0, 0, 0, 20'd5, 16'h8000);
      wait_settled();
      push("R2 R3 upper byte", 3'b001, {8'h00, model[5][15:8]}, 1'b1);

      // R4 output disable
      pins(0, 1, 1, 0, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R4 oe high mute", 3'b000, 16'h0000, 1'b0);

      // R5 standby with oe low and high
      pins(1, 0, 1, 0, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R5 standby oe low", 3'b000, 16'h0000, 1'b0);
      pins(1, 1, 1, 0, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R5 standby oe high", 3'b000, 16'h0000, 1'b0);

      // R6 signature codes
      pins(0, 0, 1, 1, 0, 20'd4, 16'h0000);
      wait_settled();
      push("R6 sig even", 3'b111, 16'h0020, 1'b1);
      pins(0, 0, 1, 1, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R6 sig odd", 3'b111, 16'h00B1, 1'b1);
      pins(0, 0, 0, 1, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R6 R3 sig byte", 3'b001, 16'h00B1, 1'b1);
      pins(0, 1, 1, 1, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R6 sig oe high mute", 3'b000, 16'h0000, 1'b0);

      // R8 inhibit: chip enable high under supply, data and address move
      for (int k = 0; k < 4; k++) begin
         pins(1, 1, 1, 0, 1, 20'd5 + 20'(k), 16'h0000);
         @(posedge clk); #1;
         push("R8 inhibit no drive", 3'b000, 16'h0000, 1'b0);
      end
      pins(1, 0, 1, 0, 1, 20'd6, 16'h0000);
      wait_settled();
      push("R8 inhibit oe low no drive", 3'b000, 16'h0000, 1'b0);
      pins(0, 0, 1, 0, 0, 20'd6, 16'h0000);
      wait_settled();
      push("R8 word 6 untouched", 3'b111, model[6], 1'b1);
      pins(0, 0, 1, 0, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R8 word 5 untouched", 3'b111, model[5], 1'b1);

      // R11 erase sweep
      @(negedge clk) erase_req = 1'b1;
      @(negedge clk) erase_req = 1'b0;
      chk_bit("R11 busy raised", busy, 1'b1);
      repeat (DEPTH - 1) @(posedge clk);
      #1;
      chk_bit("R11 busy at last word", busy, 1'b1);
      @(posedge clk); #1;
      chk_bit("R11 busy cleared", busy, 1'b0);
      for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
      pins(0, 0, 1, 0, 0, 20'd4, 16'h0000);
      wait_settled();
      push("R11 R9 word erased", 3'b111, model[5], 1'b1);
      pins(0, 0, 1, 0, 0, 20'd5, 16'h0000);
      wait_settled();
      push("R11 programmed word erased", 3'b111, 16'hFFFF, 1'b1);

      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule